// File: doc/BRIEF.md
# Sample Rate Ratio Estimator with Hysteresis

This block watches two sample strobes, one at the input sample rate and one at the output sample rate, both synchronous to a shared master clock. It measures how many master-clock cycles each side takes to produce a fixed number of strobes. It then forms the output-to-input rate ratio as an unsigned fixed-point value with one integer bit and `FRAC_W` fraction bits. A downstream decimation filter uses this value to scale its bandwidth and tap count.

When the output rate is at least the input rate, no decimation is needed. In that case the ratio is pinned to exactly 1.0 and the decimating flag is low. Otherwise a sequential divider computes the quotient. A freshly computed quotient only replaces the published one when it has moved by more than a hysteresis margin. This keeps the filter length from toggling between neighbouring values. Every change of the published value comes with a single-cycle update pulse.

Top module: `rate_ratio_tracker`

## Requirements
- R1: While reset is asserted, and after reset until the first decision is published, `ratio_o` equals 1.0 (value `1 << FRAC_W`), `decim_o` is 0 and `update_o` is 0.
- R2: Each side measures the master-clock cycles spanned by `2**WIN_LOG2` consecutive strobe intervals. Windows follow each other back to back, and the first strobe after reset opens the first window. A side with strobe period P therefore reports `P * 2**WIN_LOG2`.
- R3: When the latest input-side count is greater than or equal to the output-side count (output rate not below input rate), the candidate is exactly 1.0 (`1 << FRAC_W`) with `decim_o` 0. This includes equal rates.
- R4: When the input-side count is below the output-side count, the candidate is `floor(Nin * 2**FRAC_W / Nout)` and `decim_o` is 1.
- R5: The first decision after reset is always published, even if it equals the reset value.
- R6: A later candidate with the same decimating state replaces the published ratio only if the two differ by more than `2 << (FRAC_W - WIN_LOG2)` LSBs. This margin equals two output-period counts measured against the output window. Smaller moves leave `ratio_o` and `update_o` unchanged.
- R7: A candidate whose decimating state differs from the published one is always published.
- R8: `update_o` is high for exactly one cycle per publication. `ratio_o` and `decim_o` change only in a cycle where `update_o` is high.
- R9: `ratio_o` never exceeds 1.0, and `decim_o` is 1 exactly when `ratio_o` is below 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | One-cycle strobe per input sample |
| out_stb | input | 1 | One-cycle strobe per output sample |
| ratio_o | output | FRAC_W+1 | Published output/input rate ratio, 1.FRAC_W unsigned |
| decim_o | output | 1 | High when the published ratio is below one |
| update_o | output | 1 | One-cycle pulse when ratio_o/decim_o are republished |

## Verification
The checker holds several rules on every cycle. It checks the bound on the ratio, the tie between the decimating flag and a ratio below one, the exact 1.0 value whenever the flag is low, and the single-cycle update pulse. It also checks that no output moves without that pulse. Whether the published value is the right quotient can only be shown by the bench's scenarios. The same goes for whether small rate drifts are held back by the hysteresis margin and whether a flip between decimating and non-decimating forces a republish. For this, the bench sweeps a grid of strobe periods from reset and drives rate-change sequences.

// File: rtl/rr_pkg.sv
package rr_pkg;

    // Index of each measurement side in the counter array
    localparam int SIDE_IN  = 0;
    localparam int SIDE_OUT = 1;

    // Phase of the publish controller
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DIVIDE = 2'd1,
        PH_DECIDE = 2'd2
    } rr_phase_e;

endpackage

// File: rtl/rr_window_counter.sv
module rr_window_counter #(
    parameter int CNT_W    = 24,
    parameter int WIN_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic                armed;
        logic [WIN_LOG2-1:0] stb;
        logic [CNT_W-1:0]    cyc;
        logic                done;
        logic [CNT_W-1:0]    count;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.armed) begin
            if (strobe) begin
                st_d.armed = 1'b1;
                st_d.cyc   = '0;
                st_d.stb   = '0;
            end
        end else begin
            if (!(&st_q.cyc)) begin
                st_d.cyc = st_q.cyc + 1'b1;
            end
            if (strobe) begin
                st_d.stb = st_q.stb + 1'b1;
                if (&st_q.stb) begin
                    st_d.done  = 1'b1;
                    st_d.count = (&st_q.cyc) ? st_q.cyc : st_q.cyc + 1'b1;
                    st_d.cyc   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o  = st_q.done;
    assign count_o = st_q.count;

endmodule

// File: rtl/rr_divider.sv
module rr_divider #(
    parameter int NUM_W = 24,
    parameter int QW    = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [NUM_W-1:0] den,
    output logic             done_o,
    output logic [QW-1:0]    quot_o
);

    localparam int SW = $clog2(QW);

    typedef struct packed {
        logic             busy;
        logic [SW-1:0]    step;
        logic [NUM_W:0]   rem;
        logic [NUM_W-1:0] den;
        logic [QW-1:0]    quot;
        logic             done;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [NUM_W:0] trial;
    logic           fits;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        fits      = (st_q.rem >= {1'b0, st_q.den});
        trial     = fits ? (st_q.rem - {1'b0, st_q.den}) : st_q.rem;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.step = '0;
                st_d.rem  = {1'b0, num};
                st_d.den  = den;
                st_d.quot = '0;
            end
        end else begin
            st_d.quot = {st_q.quot[QW-2:0], fits};
            st_d.rem  = {trial[NUM_W-1:0], 1'b0};
            st_d.step = st_q.step + 1'b1;
            if (st_q.step == SW'(QW - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign quot_o = st_q.quot;

endmodule

// File: rtl/rr_publisher.sv
module rr_publisher
    import rr_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int FRAC_W   = 20,
    parameter int WIN_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_done,
    input  logic [CNT_W-1:0]  in_count,
    input  logic              out_done,
    input  logic [CNT_W-1:0]  out_count,
    input  logic              div_done,
    input  logic [FRAC_W:0]   div_quot,
    output logic              div_start,
    output logic [CNT_W-1:0]  div_num,
    output logic [CNT_W-1:0]  div_den,
    output logic [FRAC_W:0]   ratio_o,
    output logic              decim_o,
    output logic              update_o
);

    localparam int RW             = FRAC_W + 1;
    localparam logic [RW-1:0] ONE  = RW'(1) << FRAC_W;
    localparam logic [RW-1:0] HYST = RW'(2) << (FRAC_W - WIN_LOG2);

    typedef struct packed {
        logic [CNT_W-1:0] in_cnt;
        logic             in_vld;
        rr_phase_e        phase;
        logic [RW-1:0]    cand;
        logic             cand_decim;
        logic [CNT_W-1:0] num;
        logic [CNT_W-1:0] den;
        logic             start;
        logic [RW-1:0]    ratio;
        logic             decim;
        logic             upd;
        logic             seeded;
    } pub_state_t;

    pub_state_t    st_d, st_q;
    logic [RW-1:0] gap;
    logic          moved;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.upd   = 1'b0;
        gap        = (st_q.cand >= st_q.ratio) ? (st_q.cand - st_q.ratio)
                                               : (st_q.ratio - st_q.cand);
        moved      = (gap > HYST);

        if (in_done) begin
            st_d.in_cnt = in_count;
            st_d.in_vld = 1'b1;
        end

        case (st_q.phase)
            PH_IDLE: begin
                if (out_done && st_q.in_vld) begin
                    if (st_q.in_cnt >= out_count) begin
                        st_d.cand       = ONE;
                        st_d.cand_decim = 1'b0;
                        st_d.phase      = PH_DECIDE;
                    end else begin
                        st_d.num   = st_q.in_cnt;
                        st_d.den   = out_count;
                        st_d.start = 1'b1;
                        st_d.phase = PH_DIVIDE;
                    end
                end
            end
            PH_DIVIDE: begin
                if (div_done) begin
                    st_d.cand       = div_quot;
                    st_d.cand_decim = 1'b1;
                    st_d.phase      = PH_DECIDE;
                end
            end
            PH_DECIDE: begin
                if (!st_q.seeded || (st_q.cand_decim != st_q.decim) || moved) begin
                    st_d.ratio  = st_q.cand;
                    st_d.decim  = st_q.cand_decim;
                    st_d.upd    = 1'b1;
                    st_d.seeded = 1'b1;
                end
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.ratio <= ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_start = st_q.start;
    assign div_num   = st_q.num;
    assign div_den   = st_q.den;
    assign ratio_o   = st_q.ratio;
    assign decim_o   = st_q.decim;
    assign update_o  = st_q.upd;

endmodule

// File: rtl/rate_ratio_tracker.sv
module rate_ratio_tracker
    import rr_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int FRAC_W   = 20,
    parameter int WIN_LOG2 = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_stb,
    input  logic            out_stb,
    output logic [FRAC_W:0] ratio_o,
    output logic            decim_o,
    output logic            update_o
);

    localparam int RW = FRAC_W + 1;

    logic [1:0]             stb_vec;
    logic [1:0]             win_done;
    logic [1:0][CNT_W-1:0]  win_count;
    logic                   div_start;
    logic [CNT_W-1:0]       div_num;
    logic [CNT_W-1:0]       div_den;
    logic                   div_done;
    logic [RW-1:0]          div_quot;

    assign stb_vec[SIDE_IN]  = in_stb;
    assign stb_vec[SIDE_OUT] = out_stb;

    for (genvar gi = 0; gi < 2; gi++) begin : g_side
        rr_window_counter #(
            .CNT_W    (CNT_W),
            .WIN_LOG2 (WIN_LOG2)
        ) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe  (stb_vec[gi]),
            .done_o  (win_done[gi]),
            .count_o (win_count[gi])
        );
    end

    rr_divider #(
        .NUM_W (CNT_W),
        .QW    (RW)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (div_start),
        .num    (div_num),
        .den    (div_den),
        .done_o (div_done),
        .quot_o (div_quot)
    );

    rr_publisher #(
        .CNT_W    (CNT_W),
        .FRAC_W   (FRAC_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_pub (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_done   (win_done[SIDE_IN]),
        .in_count  (win_count[SIDE_IN]),
        .out_done  (win_done[SIDE_OUT]),
        .out_count (win_count[SIDE_OUT]),
        .div_done  (div_done),
        .div_quot  (div_quot),
        .div_start (div_start),
        .div_num   (div_num),
        .div_den   (div_den),
        .ratio_o   (ratio_o),
        .decim_o   (decim_o),
        .update_o  (update_o)
    );

endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
    parameter int FRAC_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic [FRAC_W:0] ratio_o,
    input logic            decim_o,
    input logic            update_o
);

    localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1) << FRAC_W;

    // R8: publication pulse lasts one cycle
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // R8: outputs move only together with the pulse
    p_change_needs_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ratio_o != $past(ratio_o)) || (decim_o != $past(decim_o))) |-> update_o);

    // R9: ratio bounded by one
    p_ratio_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_o <= ONE);

    // R9: decimating implies ratio below one
    p_decim_below_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        decim_o |-> (ratio_o < ONE));

    // R3: non-decimating means exactly one
    p_clamp_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !decim_o |-> (ratio_o == ONE));

endmodule

bind rate_ratio_tracker rr_checker #(.FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio_o  (ratio_o),
    .decim_o  (decim_o),
    .update_o (update_o)
);

// File: tb/rate_ratio_tracker_test.sv
`timescale 1ns/1ps
module rate_ratio_tracker_test;

    localparam int CNT_W    = 24;
    localparam int FRAC_W   = 20;
    localparam int WIN_LOG2 = 4;
    localparam longint ONE  = longint'(1) << FRAC_W;
    localparam longint HYST = longint'(2) << (FRAC_W - WIN_LOG2);
    localparam int WATCHDOG = 190000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_stb = 1'b0;
    logic            out_stb = 1'b0;
    logic [FRAC_W:0] ratio_o;
    logic            decim_o;
    logic            update_o;

    int nchk = 0;
    int nfail = 0;
    int upd_cnt = 0;
    int pin_per = 10;
    int pout_per = 10;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rate_ratio_tracker #(
        .CNT_W    (CNT_W),
        .FRAC_W   (FRAC_W),
        .WIN_LOG2 (WIN_LOG2)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_stb   (in_stb),
        .out_stb  (out_stb),
        .ratio_o  (ratio_o),
        .decim_o  (decim_o),
        .update_o (update_o)
    );

    // strobe generators
    initial begin
        int c = 0;
        forever begin
            @(posedge clk); #1;
            if (c >= pin_per - 1) begin in_stb = 1'b1; c = 0; end
            else begin in_stb = 1'b0; c++; end
        end
    end
    initial begin
        int c = 0;
        forever begin
            @(posedge clk); #1;
            if (c >= pout_per - 1) begin out_stb = 1'b1; c = 0; end
            else begin out_stb = 1'b0; c++; end
        end
    end

    // update pulse monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && update_o) upd_cnt++;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input longint act, input longint exp,
                            input longint tol);
        longint d;
        d = (act > exp) ? act - exp : exp - act;
        nchk++;
        if (d > tol) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d+-%0d", req, act, exp, tol);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        cycles(3);
        upd_cnt = 0;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    function automatic int settle(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return 3 * m * (1 << WIN_LOG2) + 100;
    endfunction

    function automatic longint expect_ratio(input int pi, input int po);
        if (pi >= po) return ONE;
        return (longint'(pi) << FRAC_W) / longint'(po);
    endfunction

    initial begin
        // R1: reset state
        cycles(2);
        chk("R1 ratio in reset", longint'(ratio_o), ONE);
        chk("R1 decim in reset", longint'(decim_o), 0);
        chk("R1 update in reset", longint'(update_o), 0);

        pin_per = 10; pout_per = 16;
        do_reset();
        cycles(60);
        chk("R1 ratio before first window", longint'(ratio_o), ONE);
        chk("R1 no update before first window", upd_cnt, 0);

        // R4 R5 R2: first decimating measurement
        cycles(settle(10, 16) * 2);
        chk("R4 ratio 10/16", longint'(ratio_o), expect_ratio(10, 16));
        chk("R4 decim 10/16", longint'(decim_o), 1);
        chk("R5 single publication 10/16", upd_cnt, 1);

        // R4 boundary just under one
        pin_per = 39; pout_per = 40;
        do_reset();
        cycles(settle(39, 40));
        chk("R4 ratio 39/40", longint'(ratio_o), expect_ratio(39, 40));
        chk("R4 decim 39/40", longint'(decim_o), 1);

        // R3 R5 equal rates, published although equal to reset value
        pin_per = 12; pout_per = 12;
        do_reset();
        cycles(settle(12, 12));
        chk("R3 ratio equal rates", longint'(ratio_o), ONE);
        chk("R3 decim equal rates", longint'(decim_o), 0);
        chk("R5 first publish at equal rates", upd_cnt, 1);

        // R3 output faster than input
        pin_per = 20; pout_per = 15;
        do_reset();
        cycles(settle(20, 15));
        chk("R3 ratio upsampling", longint'(ratio_o), ONE);
        chk("R3 decim upsampling", longint'(decim_o), 0);

        // R6 hysteresis hold and release
        pin_per = 30; pout_per = 40;
        do_reset();
        cycles(settle(30, 40));
        chk("R6 seed ratio 30/40", longint'(ratio_o), expect_ratio(30, 40));
        pin_per = 33;
        cycles(settle(33, 40) * 2);
        chk("R6 small drift held", longint'(ratio_o), expect_ratio(30, 40));
        chk("R6 no pulse on small drift", upd_cnt, 1);
        pin_per = 15;
        cycles(settle(15, 40) * 2);
        chk_near("R6 large drift republished", longint'(ratio_o), expect_ratio(15, 40), HYST);
        chk("R6 large drift pulse seen", longint'(upd_cnt > 1), 1);

        // R7 flag flip forces publish both ways
        pout_per = 12;
        cycles(settle(15, 12) * 2);
        chk("R7 to non-decimating ratio", longint'(ratio_o), ONE);
        chk("R7 to non-decimating flag", longint'(decim_o), 0);
        pout_per = 16;
        cycles(settle(15, 16) * 2);
        chk("R7 to decimating flag", longint'(decim_o), 1);
        chk_near("R7 to decimating ratio", longint'(ratio_o), expect_ratio(15, 16), HYST);

        // R2 R3 R4 sweep over a grid of periods
        for (int po = 8; po <= 14; po++) begin
            for (int pi = 6; pi <= 14; pi += 2) begin
                pin_per = pi; pout_per = po;
                do_reset();
                cycles(settle(pi, po));
                chk($sformatf("R2 R4 sweep ratio pi=%0d po=%0d", pi, po),
                    longint'(ratio_o), expect_ratio(pi, po));
                chk($sformatf("R3 sweep flag pi=%0d po=%0d", pi, po),
                    longint'(decim_o), (pi < po) ? 1 : 0);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

endmodule